// File: doc/BRIEF.md
# 8b/10b Transmit Character Encoder

This block turns one byte per byte-clock cycle into a 10-bit transmission character for a serializer that follows it. Four control inputs choose what is sent:
- an ordinary data character built from the byte;
- a frame delimiter (K28.5);
- a control character of the same value as the byte;
- one of three fixed K28 codes selected by a two-bit field.

Each character exists in a positive and a negative form. The encoder tracks running disparity across the stream and picks the form that keeps the line balanced.

The output word is registered. Its bit 0 is the first bit on the line. A control byte that is not one of the permitted control characters is replaced by K28.5, and an error flag is raised for that word.

Top module: `tx_char_encoder`

## Requirements
- R1: With kgen_i low and frame_i high, the word sent is K28.5 in the form set by the current running disparity (RD- form 0011111010, RD+ form 1100000101, written a to j), whatever data_i holds.
- R2: With kgen_i and frame_i low, data_i is encoded as data character D.x.y, where x = data_i[4:0] and y = data_i[7:5], following the standard 5b/6b and 3b/4b code tables. The alternate x.7 code is used for x = 17, 18, 20 at negative disparity and for x = 11, 13, 14 at positive disparity.
- R3: With kgen_i high and tk_i = 2'b00, a data_i value that names a permitted control character is sent as that control character. The permitted values are 8'h1C, 3C, 5C, 7C, 9C, BC, DC, FC (K28.0 to K28.7) and 8'hF7, FB, FD, FE (K23.7, K27.7, K29.7, K30.7).
- R4: With kgen_i high, tk_i = 2'b01 sends K28.1, 2'b10 sends K28.3 and 2'b11 sends K28.7, and data_i has no effect on the word.
- R5: With kgen_i high, tk_i = 2'b00 and data_i not permitted by R3, the word is K28.5 and err_o is 1 for that word. In every other case err_o is 0.
- R6: Every word has 4, 5 or 6 ones. A word with 6 ones is sent only at negative running disparity, and a word with 4 ones only at positive. A word with 4 or 6 ones flips the running disparity; a word with 5 ones keeps it.
- R7: While rst_ni is low, sym_o and err_o are 0 and the running disparity is negative, so the first word after reset uses its RD- form.
- R8: Inputs are captured at a rising edge of clk_i, and the word for them is on sym_o after that same edge. data_i[0] is bit A. sym_o[0] carries a, and the output runs a, b, c, d, e, i, f, g, h, j from sym_o[0] up to sym_o[9].
- R9: When kgen_i and frame_i are both high, kgen_i decides the word and frame_i is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_i | input | 8 | Byte to send, bit 0 = A |
| frame_i | input | 1 | Request a K28.5 delimiter |
| kgen_i | input | 1 | Select control-character generation |
| tk_i | input | 2 | Control code select under kgen_i |
| sym_o | output | 10 | Encoded character, sym_o[0] sent first |
| err_o | output | 1 | Illegal control byte was replaced |

## Verification
The checker assumes that inputs are stable around each rising edge of clk_i and never X after reset. Its properties start one cycle after reset is released, because the output holds zero until the first word is registered. The bench changes inputs only on falling edges and drives defined values on every cycle. The stimulus covers all 256 data bytes, every permitted and several illegal control bytes, and a long random mix of modes, so that both disparity forms of each character class appear.

// File: rtl/tx_char_encoder_pkg.sv
package tx_char_encoder_pkg;
  localparam int BYTE_W = 8;
  localparam int SYM_W  = 10;
  localparam int LO_W   = 5;
  localparam int HI_W   = BYTE_W - LO_W;
  localparam int LO_SYM = 6;
  localparam int HI_SYM = SYM_W - LO_SYM;

  localparam logic [BYTE_W-1:0] K28_1 = 8'h3C;
  localparam logic [BYTE_W-1:0] K28_3 = 8'h7C;
  localparam logic [BYTE_W-1:0] K28_5 = 8'hBC;
  localparam logic [BYTE_W-1:0] K28_7 = 8'hFC;

  typedef struct packed {
    logic [BYTE_W-1:0] val;
    logic              is_k;
    logic              bad;
  } char_req_t;

  function automatic logic k_permitted(logic [BYTE_W-1:0] b);
    return (b[LO_W-1:0] == 5'd28) ||
           (b == 8'hF7) || (b == 8'hFB) || (b == 8'hFD) || (b == 8'hFE);
  endfunction
endpackage

// File: rtl/tx_ctrl_select.sv
module tx_ctrl_select
  import tx_char_encoder_pkg::*;
(
  input  logic [BYTE_W-1:0] data_i,
  input  logic              frame_i,
  input  logic              kgen_i,
  input  logic [1:0]        tk_i,
  output char_req_t         req_o
);
  always_comb begin
    req_o.val  = data_i;
    req_o.is_k = 1'b0;
    req_o.bad  = 1'b0;
    if (kgen_i) begin
      req_o.is_k = 1'b1;
      unique case (tk_i)
        2'b00: if (!k_permitted(data_i)) begin
                 req_o.val = K28_5;
                 req_o.bad = 1'b1;
               end
        2'b01: req_o.val = K28_1;
        2'b10: req_o.val = K28_3;
        default: req_o.val = K28_7;
      endcase
    end else if (frame_i) begin
      req_o.val  = K28_5;
      req_o.is_k = 1'b1;
    end
  end
endmodule

// File: rtl/tx_enc_6b.sv
module tx_enc_6b
  import tx_char_encoder_pkg::*;
(
  input  logic [LO_W-1:0]   x_i,
  input  logic              is_k_i,
  input  logic              rd_i,    // 1 = positive
  output logic [LO_SYM-1:0] code_o,  // abcdei, a in MSB
  output logic              rd_o
);
  logic [LO_SYM-1:0] base;
  logic              unbal;

  always_comb begin
    unique case (x_i)
      5'd0:  base = 6'b100111;  5'd1:  base = 6'b011101;
      5'd2:  base = 6'b101101;  5'd3:  base = 6'b110001;
      5'd4:  base = 6'b110101;  5'd5:  base = 6'b101001;
      5'd6:  base = 6'b011001;  5'd7:  base = 6'b111000;
      5'd8:  base = 6'b111001;  5'd9:  base = 6'b100101;
      5'd10: base = 6'b010101;  5'd11: base = 6'b110100;
      5'd12: base = 6'b001101;  5'd13: base = 6'b101100;
      5'd14: base = 6'b011100;  5'd15: base = 6'b010111;
      5'd16: base = 6'b011011;  5'd17: base = 6'b100011;
      5'd18: base = 6'b010011;  5'd19: base = 6'b110010;
      5'd20: base = 6'b001011;  5'd21: base = 6'b101010;
      5'd22: base = 6'b011010;  5'd23: base = 6'b111010;
      5'd24: base = 6'b110011;  5'd25: base = 6'b100110;
      5'd26: base = 6'b010110;  5'd27: base = 6'b110110;
      5'd28: base = is_k_i ? 6'b001111 : 6'b001110;
      5'd29: base = 6'b101110;  5'd30: base = 6'b011110;
      default: base = 6'b101011;
    endcase
    unbal  = ($countones(base) != 3);
    // D7 is balanced but still has two forms
    code_o = (rd_i && (unbal || x_i == 5'd7)) ? ~base : base;
    rd_o   = rd_i ^ unbal;
  end
endmodule

// File: rtl/tx_enc_4b.sv
module tx_enc_4b
  import tx_char_encoder_pkg::*;
(
  input  logic [HI_W-1:0]   y_i,
  input  logic              is_k_i,
  input  logic              alt7_i,
  input  logic              rd_i,
  output logic [HI_SYM-1:0] code_o,  // fghj, f in MSB
  output logic              rd_o
);
  logic [HI_SYM-1:0] base;
  logic              unbal;

  always_comb begin
    unique case (y_i)
      3'd0: base = 4'b1011;
      3'd1: base = 4'b1001;
      3'd2: base = 4'b0101;
      3'd3: base = 4'b1100;
      3'd4: base = 4'b1101;
      3'd5: base = 4'b1010;
      3'd6: base = 4'b0110;
      default: base = alt7_i ? 4'b0111 : 4'b1110;
    endcase
    unbal = ($countones(base) != 2);
    if (unbal || y_i == 3'd3)
      code_o = rd_i ? ~base : base;
    else if (is_k_i)
      code_o = rd_i ? base : ~base;  // keeps control codes distinct after K28 prefix
    else
      code_o = base;
    rd_o = rd_i ^ unbal;
  end
endmodule

// File: rtl/tx_char_encoder.sv
module tx_char_encoder
  import tx_char_encoder_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              frame_i,
  input  logic              kgen_i,
  input  logic [1:0]        tk_i,
  output logic [SYM_W-1:0]  sym_o,
  output logic              err_o
);
  char_req_t         req;
  logic              rd_q, rd_6, rd_4, alt7;
  logic [LO_SYM-1:0] c6;
  logic [HI_SYM-1:0] c4;
  logic [SYM_W-1:0]  word_msb, sym_d;
  logic [LO_W-1:0]   x;

  tx_ctrl_select u_sel (
    .data_i(data_i), .frame_i(frame_i), .kgen_i(kgen_i), .tk_i(tk_i), .req_o(req)
  );

  assign x = req.val[LO_W-1:0];

  tx_enc_6b u_6b (
    .x_i(x), .is_k_i(req.is_k), .rd_i(rd_q), .code_o(c6), .rd_o(rd_6)
  );

  assign alt7 = req.is_k ||
                (!rd_6 && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
                ( rd_6 && (x == 5'd11 || x == 5'd13 || x == 5'd14));

  tx_enc_4b u_4b (
    .y_i(req.val[BYTE_W-1:LO_W]), .is_k_i(req.is_k), .alt7_i(alt7),
    .rd_i(rd_6), .code_o(c4), .rd_o(rd_4)
  );

  assign word_msb = {c6, c4};

  // a goes to bit 0 so it leaves first
  for (genvar i = 0; i < SYM_W; i++) begin : g_order
    assign sym_d[i] = word_msb[SYM_W-1-i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym_o <= '0;
      err_o <= 1'b0;
      rd_q  <= 1'b0;
    end else begin
      sym_o <= sym_d;
      err_o <= req.bad;
      rd_q  <= rd_4;
    end
  end
endmodule

// File: rtl/tx_char_encoder_chk.sv
module tx_char_encoder_chk
  import tx_char_encoder_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [BYTE_W-1:0] data_i,
  input logic              frame_i,
  input logic              kgen_i,
  input logic [1:0]        tk_i,
  input logic [SYM_W-1:0]  sym_o,
  input logic              err_o
);
  localparam logic [SYM_W-1:0] K285_N = 10'h17C;
  localparam logic [SYM_W-1:0] K285_P = 10'h283;
  localparam logic [SYM_W-1:0] K281_N = 10'h27C;
  localparam logic [SYM_W-1:0] K281_P = 10'h183;

  logic started, rd_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started <= 1'b0;
      rd_seen <= 1'b0;
    end else begin
      started <= 1'b1;
      if (started) rd_seen <= rd_seen ^ ($countones(sym_o) != 5);
    end
  end

  p_k285_frame_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started && $past(frame_i && !kgen_i) |-> (sym_o == K285_N || sym_o == K285_P));

  p_k281_sel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started && $past(kgen_i && tk_i == 2'b01) |-> (sym_o == K281_N || sym_o == K281_P));

  p_err_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started && $past(kgen_i && tk_i == 2'b00 && !k_permitted(data_i))
    |-> (err_o && (sym_o == K285_N || sym_o == K285_P)));

  p_noerr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started && !$past(kgen_i && tk_i == 2'b00 && !k_permitted(data_i)) |-> !err_o);

  p_weight_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started |-> ($countones(sym_o) >= 4 && $countones(sym_o) <= 6));

  p_rd_neg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started && $countones(sym_o) == 6 |-> !rd_seen);

  p_rd_pos_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started && $countones(sym_o) == 4 |-> rd_seen);
endmodule

bind tx_char_encoder tx_char_encoder_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .frame_i(frame_i),
  .kgen_i(kgen_i), .tk_i(tk_i), .sym_o(sym_o), .err_o(err_o)
);

// File: tb/tb_tx_char_encoder.sv
module tb_tx_char_encoder;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] data_i = '0;
  logic       frame_i = 1'b0, kgen_i = 1'b0;
  logic [1:0] tk_i = '0;
  logic [9:0] sym_o;
  logic       err_o;

  int checks = 0, errors = 0;
  int rd = -1;  // model running disparity
  bit done = 0;

  always #5 clk_i = ~clk_i;

  tx_char_encoder dut (.*);

  function automatic logic [5:0] t6(int x);
    logic [5:0] t [32] = '{6'b100111,6'b011101,6'b101101,6'b110001,6'b110101,6'b101001,
      6'b011001,6'b111000,6'b111001,6'b100101,6'b010101,6'b110100,6'b001101,6'b101100,
      6'b011100,6'b010111,6'b011011,6'b100011,6'b010011,6'b110010,6'b001011,6'b101010,
      6'b011010,6'b111010,6'b110011,6'b100110,6'b010110,6'b110110,6'b001110,6'b101110,
      6'b011110,6'b101011};
    return t[x];
  endfunction

  // reference: returns abcdeifghj with a in bit 9, advances rd
  function automatic logic [9:0] ref_char(logic [7:0] b, bit k);
    int x = b[4:0], y = b[7:5];
    logic [5:0] c6 = (k && x == 28) ? 6'b001111 : t6(x);
    logic [3:0] c4;
    bit a7;
    if ($countones(c6) != 3) begin
      if (rd > 0) c6 = ~c6;
      rd = -rd;
    end else if (x == 7 && rd > 0) c6 = ~c6;
    a7 = k || (rd < 0 && (x == 17 || x == 18 || x == 20)) ||
              (rd > 0 && (x == 11 || x == 13 || x == 14));
    case (y)
      0: c4 = 4'b1011; 1: c4 = 4'b1001; 2: c4 = 4'b0101; 3: c4 = 4'b1100;
      4: c4 = 4'b1101; 5: c4 = 4'b1010; 6: c4 = 4'b0110;
      default: c4 = a7 ? 4'b0111 : 4'b1110;
    endcase
    if ($countones(c4) != 2) begin
      if (rd > 0) c4 = ~c4;
      rd = -rd;
    end else if (y == 3) begin
      if (rd > 0) c4 = ~c4;
    end else if (k && rd < 0) c4 = ~c4;
    return {c6, c4};
  endfunction

  function automatic logic [9:0] to_port(logic [9:0] w);
    logic [9:0] r;
    for (int i = 0; i < 10; i++) r[i] = w[9-i];
    return r;
  endfunction

  function automatic bit legal_k(logic [7:0] b);
    return b[4:0] == 5'd28 || b == 8'hF7 || b == 8'hFB || b == 8'hFD || b == 8'hFE;
  endfunction

  task automatic check(string tag, logic [9:0] exp_s, bit exp_e);
    checks++;
    if (sym_o !== exp_s || err_o !== exp_e) begin
      errors++;
      $display("FAIL %s sym_o=%h err_o=%b expected sym=%h err=%b", tag, sym_o, err_o, exp_s, exp_e);
    end
  endtask

  // drive at negedge, compare after the next posedge
  task automatic step(string tag, logic [7:0] b, bit fr, bit kg, logic [1:0] tk);
    logic [7:0] v = b;
    bit k = 0, bad = 0;
    logic [9:0] e;
    data_i = b; frame_i = fr; kgen_i = kg; tk_i = tk;
    if (kg) begin
      k = 1;
      case (tk)
        2'b00: if (!legal_k(b)) begin v = 8'hBC; bad = 1; end
        2'b01: v = 8'h3C;
        2'b10: v = 8'h7C;
        default: v = 8'hFC;
      endcase
    end else if (fr) begin
      k = 1; v = 8'hBC;
    end
    e = to_port(ref_char(v, k));
    @(negedge clk_i);
    check(tag, e, bad);
    if ($countones(sym_o) < 4 || $countones(sym_o) > 6) begin
      checks++; errors++;
      $display("FAIL R6 weight sym_o=%h expected 4..6 ones", sym_o);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] ks [12] = '{8'h1C,8'h3C,8'h5C,8'h7C,8'h9C,8'hBC,8'hDC,8'hFC,8'hF7,8'hFB,8'hFD,8'hFE};
    logic [7:0] bads [5] = '{8'h00,8'hBD,8'hF8,8'h1B,8'hFF};
    repeat (3) @(negedge clk_i);
    check("R7 reset", 10'h000, 1'b0);
    rst_ni = 1'b1;
    // R7/R8: first word is K28.5 RD- form, a..j = 0011111010
    data_i = 8'h55; frame_i = 1; kgen_i = 0; tk_i = 0;
    @(negedge clk_i);
    check("R7 R8 first K28.5", 10'h17C, 1'b0);
    rd = 1;
    step("R1 frame", 8'h12, 1, 0, 2'b00);       // RD+ form, data ignored
    step("R1 frame", 8'hA7, 1, 0, 2'b00);
    for (int i = 0; i < 256; i++) step("R2 data", i[7:0], 0, 0, 2'b00);
    for (int i = 0; i < 256; i++) step("R2 R6 data", 8'(255 - i), 0, 0, 2'b00);
    for (int r = 0; r < 2; r++)
      foreach (ks[i]) begin
        step("R3 k", ks[i], 0, 1, 2'b00);
        step("R6 filler", 8'h07, 0, 0, 2'b00);
      end
    for (int t = 1; t < 4; t++)
      for (int i = 0; i < 6; i++) step("R4 fixed k", 8'(i * 41), 0, 1, 2'(t));
    foreach (bads[i]) begin
      step("R5 illegal", bads[i], 0, 1, 2'b00);
      step("R5 err clear", bads[i], 0, 0, 2'b00);
    end
    step("R9 kgen over frame", 8'hF7, 1, 1, 2'b00);
    step("R9 kgen over frame", 8'h00, 1, 1, 2'b11);
    step("R9 kgen over frame", 8'h01, 1, 1, 2'b00);
    for (int i = 0; i < 3000; i++) begin
      int m = $urandom_range(0, 9);
      step("R2 R6 random", 8'($urandom), m == 0, m == 1 || m == 2, 2'($urandom));
    end
    rst_ni = 1'b0;
    #1;
    check("R7 async reset", 10'h000, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1; rd = -1;
    step("R7 rd after reset", 8'h00, 0, 0, 2'b00);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule